// File: doc/BRIEF.md
# Boundary-Scan Instruction Register with Parity Fallback

This block holds the instruction of a boundary-scan test port. It is an 8-bit serial register with a parallel shadow stage. The test clock drives it. State-indicator inputs come from an existing test-access-port controller. While the controller is in its capture-instruction state, the serial stage loads a fixed recognition pattern. While it is in the shift-instruction state, the stage moves one bit per clock from the serial input toward the serial output. While it is in the update-instruction state, the falling clock edge copies the serial stage into the shadow stage, and the shadow stage holds the active instruction.

The active instruction is checked for even parity over all eight bits, with the top bit as the parity bit. A code with odd parity runs as the bypass instruction, and so does a code that is not in the supported set. The decoded instruction drives a one-hot select over four data registers: bypass, identification, boundary and a device-specific register. It also drives a flag that puts the part in test mode, which blocks its normal function. The serial output changes on the falling edge. It is enabled only while shifting.

Top module: `scan_instr_reg`

## Requirements
- R1: While `trst_n` is low, and on the falling edge of any clock cycle in which `tlr_st` is high, the active instruction becomes 8'h81 (identification). After that, `instr` reads 8'h81 and `dr_sel` reads 4'b0010.
- R2: On the rising edge of a cycle with `cap_st` high, the serial stage loads 8'h81. The next eight shifted-out bits are therefore 1,0,0,0,0,0,0,1, bit 0 first.
- R3: On the rising edge of each cycle with `shift_st` high, the serial stage moves one place toward bit 0, and `tdi` enters bit 7. `tdo` presents bit 0 of the serial stage.
- R4: `tdo` and `tdo_en` change only on the falling edge. `tdo_en` is high exactly in the half-cycle after a falling edge taken with `shift_st` high.
- R5: On the falling edge of a cycle with `upd_st` high, the serial stage is copied into the shadow stage. Before that edge the active instruction is unchanged.
- R6: In a cycle where none of `cap_st`, `shift_st` or `tlr_st` is high, the serial stage keeps its value. A scan paused for any number of cycles therefore resumes with no loss of bits.
- R7: A shadow value with an odd number of ones runs as bypass: `instr` reads 8'hFF, `dr_sel` reads 4'b0001 and `test_mode` is low.
- R8: A shadow value with even parity that is not one of the six supported codes runs as bypass, in the same way as R7.
- R9: The six supported codes decode as follows:
  - 8'hFF: bypass, `dr_sel` bit 0, normal mode.
  - 8'h81: identification, bit 1, normal mode.
  - 8'h82: sample, bit 2, normal mode.
  - 8'h00: external test, bit 2, test mode.
  - 8'h84: device register, bit 3, normal mode.
  - 8'h06: quiet test, bit 0, test mode.
- R10: `dr_sel` has exactly one bit set at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous power-up reset, active low |
| tlr_st | input | 1 | Controller is in test-logic-reset |
| cap_st | input | 1 | Controller is in capture-instruction |
| shift_st | input | 1 | Controller is in shift-instruction |
| upd_st | input | 1 | Controller is in update-instruction |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, valid when `tdo_en` is high |
| tdo_en | output | 1 | Output driver enable |
| instr | output | 8 | Effective active instruction after fallback |
| dr_sel | output | 4 | One-hot data-register select |
| test_mode | output | 1 | Normal function blocked |

## Verification
The hardest case to reach is a scan that is paused partway and then resumed. The bits shifted out after the pause must continue the recognition pattern exactly, and the opcode that lands in the shadow stage must still be the one shifted in. The stimulus splits every instruction scan into two shift bursts with idle cycles between them. A behavioural queue model follows each bit on every clock. Opcodes with odd parity and unlisted opcodes with even parity are scanned in the same way, so that the fallback path is exercised through a complete scan.

// File: rtl/sir_pkg.sv
package sir_pkg;
   localparam int OP_W   = 8;
   localparam int NUM_DR = 4;

   typedef enum logic [1:0] {
      DR_BYPASS   = 2'd0,
      DR_IDENT    = 2'd1,
      DR_BOUNDARY = 2'd2,
      DR_DEVICE   = 2'd3
   } dr_id_t;

   localparam logic [OP_W-1:0] OP_BYPASS = 8'hFF;
   localparam logic [OP_W-1:0] OP_IDENT  = 8'h81;
   localparam logic [OP_W-1:0] OP_SAMPLE = 8'h82;
   localparam logic [OP_W-1:0] OP_EXTEST = 8'h00;
   localparam logic [OP_W-1:0] OP_DEVICE = 8'h84;
   localparam logic [OP_W-1:0] OP_QUIET  = 8'h06;

   typedef struct packed {
      logic [OP_W-1:0] op;
      dr_id_t          dr;
      logic            test;
   } instr_info_t;

   function automatic instr_info_t lookup(input logic [OP_W-1:0] code, input logic par_ok);
      instr_info_t r;
      r = '{op: OP_BYPASS, dr: DR_BYPASS, test: 1'b0};
      if (par_ok) begin
         unique case (code)
            OP_IDENT:  r = '{op: OP_IDENT,  dr: DR_IDENT,    test: 1'b0};
            OP_SAMPLE: r = '{op: OP_SAMPLE, dr: DR_BOUNDARY, test: 1'b0};
            OP_EXTEST: r = '{op: OP_EXTEST, dr: DR_BOUNDARY, test: 1'b1};
            OP_DEVICE: r = '{op: OP_DEVICE, dr: DR_DEVICE,   test: 1'b0};
            OP_QUIET:  r = '{op: OP_QUIET,  dr: DR_BYPASS,   test: 1'b1};
            default:   r = '{op: OP_BYPASS, dr: DR_BYPASS,   test: 1'b0};
         endcase
      end
      return r;
   endfunction
endpackage

// File: rtl/sir_shift_stage.sv
module sir_shift_stage #(
   parameter int          W       = 8,
   parameter logic [W-1:0] CAPT_VAL = '0
) (
   input  logic         tck,
   input  logic         trst_n,
   input  logic         cap_st,
   input  logic         shift_st,
   input  logic         tdi,
   output logic [W-1:0] sr_q
);
   generate
      if (W < 2) begin : g_bad_w
         $error("sir_shift_stage: W must be at least 2");
      end
   endgenerate

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)       sr_q <= CAPT_VAL;
      else if (cap_st)   sr_q <= CAPT_VAL;
      else if (shift_st) sr_q <= {tdi, sr_q[W-1:1]};
   end
endmodule

// File: rtl/sir_shadow.sv
module sir_shadow #(
   parameter int          W       = 8,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         tck,
   input  logic         trst_n,
   input  logic         tlr_st,
   input  logic         upd_st,
   input  logic [W-1:0] sr_q,
   output logic [W-1:0] shadow_q
);
   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n)     shadow_q <= RST_VAL;
      else if (tlr_st) shadow_q <= RST_VAL;
      else if (upd_st) shadow_q <= sr_q;
   end
endmodule

// File: rtl/sir_tdo_stage.sv
module sir_tdo_stage (
   input  logic tck,
   input  logic trst_n,
   input  logic shift_st,
   input  logic lsb,
   output logic tdo,
   output logic tdo_en
);
   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) begin
         tdo    <= 1'b0;
         tdo_en <= 1'b0;
      end else begin
         tdo_en <= shift_st;
         if (shift_st) tdo <= lsb;
      end
   end
endmodule

// File: rtl/sir_decode.sv
module sir_decode #(
   parameter int W            = 8,
   parameter int NUM_DR       = 4,
   parameter bit PARITY_CHECK = 1'b1
) (
   input  logic [W-1:0]      shadow_q,
   output logic [W-1:0]      instr,
   output logic [NUM_DR-1:0] dr_sel,
   output logic              test_mode
);
   import sir_pkg::*;

   generate
      if (W != OP_W) begin : g_bad_w
         $error("sir_decode: opcode table is fixed at OP_W bits");
      end
      if (NUM_DR != sir_pkg::NUM_DR) begin : g_bad_dr
         $error("sir_decode: select width must match data register count");
      end
   endgenerate

   logic        par_ok;
   instr_info_t info;

   generate
      if (PARITY_CHECK) begin : g_par
         assign par_ok = ~^shadow_q;
      end else begin : g_nopar
         assign par_ok = 1'b1;
      end
   endgenerate

   assign info      = lookup(shadow_q, par_ok);
   assign instr     = info.op;
   assign test_mode = info.test;

   for (genvar g = 0; g < NUM_DR; g++) begin : g_sel
      assign dr_sel[g] = (info.dr == dr_id_t'(g));
   end
endmodule

// File: rtl/scan_instr_reg.sv
module scan_instr_reg #(
   parameter int IR_LEN       = sir_pkg::OP_W,
   parameter int NUM_DR       = sir_pkg::NUM_DR,
   parameter bit PARITY_CHECK = 1'b1
) (
   input  logic              tck,
   input  logic              trst_n,
   input  logic              tlr_st,
   input  logic              cap_st,
   input  logic              shift_st,
   input  logic              upd_st,
   input  logic              tdi,
   output logic              tdo,
   output logic              tdo_en,
   output logic [IR_LEN-1:0] instr,
   output logic [NUM_DR-1:0] dr_sel,
   output logic              test_mode
);
   localparam logic [IR_LEN-1:0] CAPT_VAL = sir_pkg::OP_IDENT;
   localparam logic [IR_LEN-1:0] RST_VAL  = sir_pkg::OP_IDENT;

   generate
      if (IR_LEN != sir_pkg::OP_W) begin : g_bad_len
         $error("scan_instr_reg: IR_LEN must equal the opcode width");
      end
   endgenerate

   logic [IR_LEN-1:0] sr_q;
   logic [IR_LEN-1:0] shadow_q;

   sir_shift_stage #(.W(IR_LEN), .CAPT_VAL(CAPT_VAL)) u_shift (
      .tck(tck), .trst_n(trst_n), .cap_st(cap_st), .shift_st(shift_st),
      .tdi(tdi), .sr_q(sr_q));

   sir_shadow #(.W(IR_LEN), .RST_VAL(RST_VAL)) u_shadow (
      .tck(tck), .trst_n(trst_n), .tlr_st(tlr_st), .upd_st(upd_st),
      .sr_q(sr_q), .shadow_q(shadow_q));

   sir_tdo_stage u_tdo (
      .tck(tck), .trst_n(trst_n), .shift_st(shift_st), .lsb(sr_q[0]),
      .tdo(tdo), .tdo_en(tdo_en));

   sir_decode #(.W(IR_LEN), .NUM_DR(NUM_DR), .PARITY_CHECK(PARITY_CHECK)) u_dec (
      .shadow_q(shadow_q), .instr(instr), .dr_sel(dr_sel), .test_mode(test_mode));
endmodule

// File: rtl/sir_checker.sv
module sir_checker #(
   parameter int IR_LEN = 8,
   parameter int NUM_DR = 4
) (
   input logic              tck,
   input logic              trst_n,
   input logic              tlr_st,
   input logic              cap_st,
   input logic              shift_st,
   input logic              tdo_en,
   input logic [IR_LEN-1:0] sr_q,
   input logic [IR_LEN-1:0] shadow_q,
   input logic [IR_LEN-1:0] instr,
   input logic [NUM_DR-1:0] dr_sel
);
   logic ready;
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) ready <= 1'b0;
      else         ready <= 1'b1;
   end

   AST_SEL_ONEHOT: assert property (@(posedge tck) disable iff (!trst_n)
      $onehot(dr_sel)); // R10

   AST_TDO_EN_ONLY_SHIFT: assert property (@(posedge tck) disable iff (!trst_n || !ready)
      tdo_en |-> shift_st); // R4

   AST_CAPTURE_LOAD: assert property (@(posedge tck) disable iff (!trst_n)
      cap_st |=> (sr_q == sir_pkg::OP_IDENT)); // R2

   AST_PAUSE_HOLD: assert property (@(posedge tck) disable iff (!trst_n || !ready)
      (!cap_st && !shift_st) |=> $stable(sr_q)); // R6

   AST_RESET_IDCODE: assert property (@(negedge tck) disable iff (!trst_n)
      tlr_st |=> (instr == sir_pkg::OP_IDENT)); // R1

   AST_BAD_PARITY_BYPASS: assert property (@(posedge tck) disable iff (!trst_n)
      (^shadow_q) |-> (dr_sel[0] && instr == sir_pkg::OP_BYPASS)); // R7
endmodule

bind scan_instr_reg sir_checker #(.IR_LEN(IR_LEN), .NUM_DR(NUM_DR)) u_sir_chk (
   .tck(tck), .trst_n(trst_n), .tlr_st(tlr_st), .cap_st(cap_st),
   .shift_st(shift_st), .tdo_en(tdo_en), .sr_q(sr_q), .shadow_q(shadow_q),
   .instr(instr), .dr_sel(dr_sel));

// File: tb/tb_scan_instr_reg.sv
module tb_scan_instr_reg;
   localparam int TCK_PERIOD = 10;
   localparam int S_IDLE = 0, S_TLR = 1, S_CAP = 2, S_SH = 3, S_UPD = 4;

   logic       tck = 1'b0;
   logic       trst_n = 1'b0;
   logic       tlr_st = 0, cap_st = 0, shift_st = 0, upd_st = 0, tdi = 0;
   logic       tdo, tdo_en, test_mode;
   logic [7:0] instr;
   logic [3:0] dr_sel;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   bit         mq[$];
   logic [7:0] m_shadow = 8'h81;
   bit         m_en = 0;
   bit         m_tdo = 0;
   bit         outq[$];

   always #(TCK_PERIOD/2) tck = ~tck;

   scan_instr_reg dut (
      .tck(tck), .trst_n(trst_n), .tlr_st(tlr_st), .cap_st(cap_st),
      .shift_st(shift_st), .upd_st(upd_st), .tdi(tdi), .tdo(tdo),
      .tdo_en(tdo_en), .instr(instr), .dr_sel(dr_sel), .test_mode(test_mode));

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic m_load(input logic [7:0] v);
      mq.delete();
      for (int i = 0; i < 8; i++) mq.push_back(v[i]);
   endtask

   function automatic logic [7:0] m_value();
      logic [7:0] v;
      for (int i = 0; i < 8; i++) v[i] = mq[i];
      return v;
   endfunction

   task automatic exp_dec(input logic [7:0] raw, output logic [7:0] eff,
                          output logic [3:0] sel, output bit tm);
      eff = 8'hFF; sel = 4'b0001; tm = 0;
      if ($countones(raw) % 2 == 0) begin
         case (raw)
            8'h81: begin eff = raw; sel = 4'b0010; end
            8'h82: begin eff = raw; sel = 4'b0100; end
            8'h00: begin eff = raw; sel = 4'b0100; tm = 1; end
            8'h84: begin eff = raw; sel = 4'b1000; end
            8'h06: begin eff = raw; sel = 4'b0001; tm = 1; end
            default: ;
         endcase
      end
   endtask

   task automatic compare_all();
      logic [7:0] e_op; logic [3:0] e_sel; bit e_tm;
      exp_dec(m_shadow, e_op, e_sel, e_tm);
      chk(tdo_en == m_en, "R4 tdo_en", tdo_en, m_en);
      if (m_en) chk(tdo == m_tdo, "R3 tdo", tdo, m_tdo);
      chk(instr == e_op, "R5 instr", instr, e_op);
      chk(dr_sel == e_sel, "R9 dr_sel", dr_sel, e_sel);
      chk(test_mode == e_tm, "R9 test_mode", test_mode, e_tm);
      chk($onehot(dr_sel), "R10 onehot", dr_sel, 0);
   endtask

   // one controller cycle: drive after rising edge, model and check at falling edge,
   // advance model at the next rising edge
   task automatic cycle(input int st, input bit d);
      #1;
      tlr_st = (st == S_TLR); cap_st = (st == S_CAP);
      shift_st = (st == S_SH); upd_st = (st == S_UPD); tdi = d;
      @(negedge tck);
      if (st == S_TLR) m_shadow = 8'h81;
      else if (st == S_UPD) m_shadow = m_value();
      m_en = (st == S_SH);
      if (st == S_SH) begin m_tdo = mq[0]; outq.push_back(mq[0]); end
      #1;
      compare_all();
      @(posedge tck);
      if (st == S_CAP) m_load(8'h81);
      else if (st == S_SH) begin void'(mq.pop_front()); mq.push_back(d); end
   endtask

   task automatic scan_ir(input logic [7:0] op, input int pause_len, input string tag);
      logic [7:0] got; logic [7:0] e_op; logic [3:0] e_sel; bit e_tm;
      outq.delete();
      cycle(S_CAP, 0);
      for (int i = 0; i < 3; i++) cycle(S_SH, op[i]);
      for (int i = 0; i < pause_len; i++) cycle(S_IDLE, 0);
      for (int i = 3; i < 8; i++) cycle(S_SH, op[i]);
      cycle(S_IDLE, 0);
      for (int i = 0; i < 8; i++) got[i] = outq[i];
      chk(got == 8'h81, pause_len > 0 ? "R6 paused capture stream" : "R2 capture stream", got, 8'h81);
      cycle(S_UPD, 0);
      cycle(S_IDLE, 0);
      exp_dec(op, e_op, e_sel, e_tm);
      chk(instr == e_op && dr_sel == e_sel && test_mode == e_tm, tag,
          {instr, 4'h0, dr_sel, 15'h0, test_mode}, {e_op, 4'h0, e_sel, 15'h0, e_tm});
   endtask

   initial begin
      #(TCK_PERIOD * 200000);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      m_load(8'h81);
      repeat (3) @(posedge tck);
      #2;
      chk(instr == 8'h81 && dr_sel == 4'b0010, "R1 reset value", {instr, dr_sel}, {8'h81, 4'b0010});
      chk(tdo_en == 0, "R4 reset enable", tdo_en, 0);
      trst_n = 1;
      @(posedge tck);
      cycle(S_IDLE, 0);
      scan_ir(8'hFF, 0, "R9 bypass");
      scan_ir(8'h00, 2, "R9 extest");
      scan_ir(8'h82, 5, "R9 sample");
      scan_ir(8'h84, 1, "R9 device");
      scan_ir(8'h06, 0, "R9 quiet");
      scan_ir(8'h01, 3, "R7 odd parity 01");
      scan_ir(8'h84, 0, "R9 device again");
      scan_ir(8'h83, 0, "R7 odd parity 83");
      scan_ir(8'h03, 2, "R8 unsupported 03");
      scan_ir(8'h00, 0, "R9 extest again");
      scan_ir(8'h90, 1, "R8 unsupported 90");
      scan_ir(8'h82, 0, "R9 sample again");
      cycle(S_TLR, 0);
      cycle(S_IDLE, 0);
      chk(instr == 8'h81 && dr_sel == 4'b0010, "R1 logic reset", {instr, dr_sel}, {8'h81, 4'b0010});
      scan_ir(8'h81, 4, "R9 ident");
      // update straight after capture loads the capture value
      scan_ir(8'hFF, 0, "R9 bypass last");
      cycle(S_CAP, 0);
      cycle(S_UPD, 0);
      cycle(S_IDLE, 0);
      chk(instr == 8'h81, "R5 update after capture", instr, 8'h81);
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule